// File: doc/BRIEF.md
# Colour LCD Controller Register Block

This block is the bus-facing register file of a colour LCD controller. A host reaches it through a simple single-cycle slave port that carries a word address covering a 4 KB window. The block stores the four panel timing words, the frame base addresses for the upper and lower panel halves, the control word and the interrupt mask. It keeps a raw interrupt status that outside event lines set and that software clears. It answers reads of a fixed identification signature, and it passes accesses in the palette window straight through to a separate palette memory.

The block decodes a few fields from the stored words and drives them out continuously to the pixel pipeline. These are the active line width in pixels, the number of lines, the pixel-depth code, the colour and endian ordering flags, and a single display-enable flag. A static strap input selects a board variant in which the control word and the mask word trade addresses. Read data, the read strobe, the error flag and the interrupt line are all registered.

Top module: `lcdc_regs`

## Requirements
- R1: After reset every stored word and the raw status are zero. The derived outputs then show a width of 16, a line count of 1, display disabled and irq low.
- R2: Byte offsets 0x00–0x0C (timing 0–3), 0x10 (upper base) and 0x14 (lower base) keep all 32 written bits and read them back. The base words also appear on upper_base_o and lower_base_o.
- R3: line_width_o equals 16 × (timing-0 bits [7:2] + 1), with a range of 16 to 1024. line_count_o equals timing-1 bits [9:0] + 1. All other timing bits have no effect on either value.
- R4: Control bit 0 is enable, bits [3:1] are depth_o, bit 8 is bgr_o, bit 9 is be_byte_o, bit 10 is be_pixel_o and bit 11 is power. disp_en_o is high only when enable and power are both set.
- R5: With the strap low, offset 0x18 is the mask and 0x1C is control. With the strap high the two addresses are swapped.
- R6: A high bit on evt_i sets the matching raw status bit. Offset 0x20 reads raw status and offset 0x24 reads raw AND mask, both zero-extended.
- R7: Writing offset 0x28 clears each raw bit that is set in the written value. If an event arrives for a bit in the same cycle as the clear, the set wins.
- R8: irq_o is the OR of the masked status bits. It is registered, so it changes one cycle after the status or the mask changes.
- R9: Offsets 0x2C and 0x30 are read-only and return the upper and lower base words.
- R10: Offsets 0xFE0 through 0xFFC are read-only and return, in rising address order, the bytes 0x10, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R11: Offsets 0x200–0x3FC are forwarded to the palette port, with pal_idx_o equal to the byte offset bits [8:2]. A read there returns pal_rdata_i one cycle later.
- R12: An access is bad if it targets an unmapped offset, writes a read-only offset, or reads offset 0x28. A bad read returns zero, a bad write changes nothing, and err_o pulses in the cycle after the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| strap_swap_i | input | 1 | Board variant: swap control and mask addresses |
| sel_i | input | 1 | Access request this cycle |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 10 | Word address (byte offset bits [11:2]) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data strobe, one cycle after a read |
| err_o | output | 1 | Bad-access pulse, one cycle after the access |
| evt_i | input | 4 | Interrupt event lines |
| irq_o | output | 1 | Registered interrupt request |
| pal_sel_o | output | 1 | Palette access strobe |
| pal_wr_o | output | 1 | Palette write |
| pal_idx_o | output | 7 | Palette word index |
| pal_wdata_o | output | 32 | Palette write data |
| pal_rdata_i | input | 32 | Palette read data, same cycle as pal_sel_o |
| line_width_o | output | 11 | Pixels per line |
| line_count_o | output | 11 | Lines per panel |
| depth_o | output | 3 | Pixel-depth code |
| bgr_o | output | 1 | Blue/red swap |
| be_byte_o | output | 1 | Big-endian byte order |
| be_pixel_o | output | 1 | Big-endian pixel order within a byte |
| disp_en_o | output | 1 | Display enabled (enable and power) |
| upper_base_o | output | 32 | Upper panel frame base |
| lower_base_o | output | 32 | Lower panel frame base |

## Verification
An event on evt_i and a host write to the clear register can arrive in the same cycle and touch the same raw status bit. The bench provokes this by raising an event on one bit while it writes a clear word that covers that bit and one other bit. It then reads raw and masked status and samples irq_o. The expected result is that the event bit stays set, the other covered bit is cleared, and the interrupt stays asserted.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;

    localparam int DATA_W      = 32;
    localparam int WORD_W      = 10;
    localparam int PAL_IDX_W   = 7;
    localparam int PPL_FIELD_W = 6;
    localparam int LPP_FIELD_W = 10;
    localparam int LW_W        = PPL_FIELD_W + 5;
    localparam int LC_W        = LPP_FIELD_W + 1;
    localparam int N_TIM       = 4;
    localparam int TIM_IDX_W   = $clog2(N_TIM);

    // control word bit positions (decoded by the pixel pipeline)
    localparam int CB_EN    = 0;
    localparam int CB_DEPLO = 1;
    localparam int CB_BGR   = 8;
    localparam int CB_BEBY  = 9;
    localparam int CB_BEPX  = 10;
    localparam int CB_PWR   = 11;

    typedef enum logic [3:0] {
        TGT_NONE,
        TGT_TIM,
        TGT_UBASE,
        TGT_LBASE,
        TGT_MASK,
        TGT_CTRL,
        TGT_RAW,
        TGT_MIS,
        TGT_CLR,
        TGT_UCUR,
        TGT_LCUR,
        TGT_ID,
        TGT_PAL
    } tgt_e;

    function automatic logic [7:0] sig_byte(input logic [2:0] idx);
        logic [7:0] b;
        case (idx)
            3'd0:    b = 8'h10;
            3'd1:    b = 8'h11;
            3'd2:    b = 8'h04;
            3'd3:    b = 8'h00;
            3'd4:    b = 8'h0D;
            3'd5:    b = 8'hF0;
            3'd6:    b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/lcdc_addr_decode.sv
module lcdc_addr_decode
    import lcdc_pkg::*;
(
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic              swap_i,
    input  logic [WORD_W-1:0] word_i,
    output tgt_e              tgt_o,
    output logic              bad_o
);

    logic ro;

    always_comb begin
        tgt_o = TGT_NONE;
        if (word_i[WORD_W-1:PAL_IDX_W] == 3'b001) begin
            tgt_o = TGT_PAL;
        end else if (&word_i[WORD_W-1:3]) begin
            tgt_o = TGT_ID;
        end else if (word_i[WORD_W-1:4] == '0) begin
            case (word_i[3:0])
                4'd0, 4'd1, 4'd2, 4'd3: tgt_o = TGT_TIM;
                4'd4:  tgt_o = TGT_UBASE;
                4'd5:  tgt_o = TGT_LBASE;
                4'd6:  tgt_o = swap_i ? TGT_CTRL : TGT_MASK;
                4'd7:  tgt_o = swap_i ? TGT_MASK : TGT_CTRL;
                4'd8:  tgt_o = TGT_RAW;
                4'd9:  tgt_o = TGT_MIS;
                4'd10: tgt_o = TGT_CLR;
                4'd11: tgt_o = TGT_UCUR;
                4'd12: tgt_o = TGT_LCUR;
                default: tgt_o = TGT_NONE;
            endcase
        end
    end

    always_comb begin
        ro = (tgt_o == TGT_RAW) || (tgt_o == TGT_MIS) || (tgt_o == TGT_UCUR)
          || (tgt_o == TGT_LCUR) || (tgt_o == TGT_ID);
        bad_o = sel_i && ((tgt_o == TGT_NONE)
                       || (wr_i && ro)
                       || (!wr_i && (tgt_o == TGT_CLR)));
    end

endmodule

// File: rtl/lcdc_irq_ctrl.sv
module lcdc_irq_ctrl #(
    parameter int N_IRQ = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [N_IRQ-1:0] evt_i,
    input  logic             mask_we_i,
    input  logic [N_IRQ-1:0] mask_wdata_i,
    input  logic             clr_we_i,
    input  logic [N_IRQ-1:0] clr_wdata_i,
    output logic [N_IRQ-1:0] raw_o,
    output logic [N_IRQ-1:0] mask_o,
    output logic             irq_o
);

    typedef struct packed {
        logic [N_IRQ-1:0] raw;
        logic [N_IRQ-1:0] mask;
        logic             irq;
    } irq_state_t;

    irq_state_t st_d, st_q;

    always_comb begin
        logic [N_IRQ-1:0] kill;
        st_d = st_q;
        kill = clr_we_i ? clr_wdata_i : '0;
        // an event in the same cycle as a clear keeps its bit set
        st_d.raw = (st_q.raw & ~kill) | evt_i;
        if (mask_we_i) begin
            st_d.mask = mask_wdata_i;
        end
        st_d.irq = |(st_q.raw & st_q.mask);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign raw_o  = st_q.raw;
    assign mask_o = st_q.mask;
    assign irq_o  = st_q.irq;

endmodule

// File: rtl/lcdc_geom.sv
module lcdc_geom
    import lcdc_pkg::*;
(
    input  logic [PPL_FIELD_W-1:0] ppl_field_i,
    input  logic [LPP_FIELD_W-1:0] lpp_field_i,
    input  logic                   en_i,
    input  logic                   pwr_i,
    output logic [LW_W-1:0]        line_width_o,
    output logic [LC_W-1:0]        line_count_o,
    output logic                   disp_en_o
);

    logic [LW_W-5:0] groups;

    always_comb begin
        groups       = {1'b0, ppl_field_i} + 1'b1;
        line_width_o = {groups, 4'b0000};
        line_count_o = {1'b0, lpp_field_i} + 1'b1;
        disp_en_o    = en_i && pwr_i;
    end

endmodule

// File: rtl/lcdc_regs.sv
module lcdc_regs
    import lcdc_pkg::*;
#(
    parameter int N_IRQ = 4
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 strap_swap_i,
    input  logic                 sel_i,
    input  logic                 wr_i,
    input  logic [WORD_W-1:0]    addr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    output logic [DATA_W-1:0]    rdata_o,
    output logic                 rvalid_o,
    output logic                 err_o,
    input  logic [N_IRQ-1:0]     evt_i,
    output logic                 irq_o,
    output logic                 pal_sel_o,
    output logic                 pal_wr_o,
    output logic [PAL_IDX_W-1:0] pal_idx_o,
    output logic [DATA_W-1:0]    pal_wdata_o,
    input  logic [DATA_W-1:0]    pal_rdata_i,
    output logic [LW_W-1:0]      line_width_o,
    output logic [LC_W-1:0]      line_count_o,
    output logic [2:0]           depth_o,
    output logic                 bgr_o,
    output logic                 be_byte_o,
    output logic                 be_pixel_o,
    output logic                 disp_en_o,
    output logic [DATA_W-1:0]    upper_base_o,
    output logic [DATA_W-1:0]    lower_base_o
);

    typedef struct packed {
        logic [N_TIM-1:0][DATA_W-1:0] tim;
        logic [DATA_W-1:0]            ubase;
        logic [DATA_W-1:0]            lbase;
        logic [DATA_W-1:0]            ctrl;
        logic [DATA_W-1:0]            rdata;
        logic                         rvalid;
        logic                         err;
    } reg_state_t;

    reg_state_t s_d, s_q;

    tgt_e             tgt;
    logic             bad;
    logic             ok_wr;
    logic             ok_rd;
    logic [N_IRQ-1:0] raw_w;
    logic [N_IRQ-1:0] mask_w;
    logic [DATA_W-1:0] rd_mux;
    logic [TIM_IDX_W-1:0] tim_idx;

    lcdc_addr_decode u_dec (
        .sel_i  (sel_i),
        .wr_i   (wr_i),
        .swap_i (strap_swap_i),
        .word_i (addr_i),
        .tgt_o  (tgt),
        .bad_o  (bad)
    );

    assign ok_wr   = sel_i && wr_i && !bad;
    assign ok_rd   = sel_i && !wr_i && !bad;
    assign tim_idx = addr_i[TIM_IDX_W-1:0];

    lcdc_irq_ctrl #(.N_IRQ(N_IRQ)) u_irq (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .evt_i        (evt_i),
        .mask_we_i    (ok_wr && (tgt == TGT_MASK)),
        .mask_wdata_i (wdata_i[N_IRQ-1:0]),
        .clr_we_i     (ok_wr && (tgt == TGT_CLR)),
        .clr_wdata_i  (wdata_i[N_IRQ-1:0]),
        .raw_o        (raw_w),
        .mask_o       (mask_w),
        .irq_o        (irq_o)
    );

    // read multiplexer
    always_comb begin
        rd_mux = '0;
        case (tgt)
            TGT_TIM:   rd_mux = s_q.tim[tim_idx];
            TGT_UBASE,
            TGT_UCUR:  rd_mux = s_q.ubase;
            TGT_LBASE,
            TGT_LCUR:  rd_mux = s_q.lbase;
            TGT_CTRL:  rd_mux = s_q.ctrl;
            TGT_MASK:  rd_mux = {{(DATA_W-N_IRQ){1'b0}}, mask_w};
            TGT_RAW:   rd_mux = {{(DATA_W-N_IRQ){1'b0}}, raw_w};
            TGT_MIS:   rd_mux = {{(DATA_W-N_IRQ){1'b0}}, raw_w & mask_w};
            TGT_ID:    rd_mux = {{(DATA_W-8){1'b0}}, sig_byte(addr_i[2:0])};
            TGT_PAL:   rd_mux = pal_rdata_i;
            default:   rd_mux = '0;
        endcase
    end

    // next-state computation
    always_comb begin
        s_d        = s_q;
        s_d.rvalid = sel_i && !wr_i;
        s_d.err    = bad;
        if (sel_i && !wr_i) begin
            s_d.rdata = ok_rd ? rd_mux : '0;
        end
        if (ok_wr) begin
            case (tgt)
                TGT_TIM:   s_d.tim[tim_idx] = wdata_i;
                TGT_UBASE: s_d.ubase = wdata_i;
                TGT_LBASE: s_d.lbase = wdata_i;
                TGT_CTRL:  s_d.ctrl  = wdata_i;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // palette pass-through
    assign pal_sel_o   = sel_i && (tgt == TGT_PAL);
    assign pal_wr_o    = wr_i;
    assign pal_idx_o   = addr_i[PAL_IDX_W-1:0];
    assign pal_wdata_o = wdata_i;

    lcdc_geom u_geom (
        .ppl_field_i  (s_q.tim[0][PPL_FIELD_W+1:2]),
        .lpp_field_i  (s_q.tim[1][LPP_FIELD_W-1:0]),
        .en_i         (s_q.ctrl[CB_EN]),
        .pwr_i        (s_q.ctrl[CB_PWR]),
        .line_width_o (line_width_o),
        .line_count_o (line_count_o),
        .disp_en_o    (disp_en_o)
    );

    assign depth_o      = s_q.ctrl[CB_DEPLO+2:CB_DEPLO];
    assign bgr_o        = s_q.ctrl[CB_BGR];
    assign be_byte_o    = s_q.ctrl[CB_BEBY];
    assign be_pixel_o   = s_q.ctrl[CB_BEPX];
    assign upper_base_o = s_q.ubase;
    assign lower_base_o = s_q.lbase;
    assign rdata_o      = s_q.rdata;
    assign rvalid_o     = s_q.rvalid;
    assign err_o        = s_q.err;

endmodule

// File: rtl/lcdc_regs_chk.sv
module lcdc_regs_chk #(
    parameter int N_IRQ = 4
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             sel_i,
    input logic             wr_i,
    input logic [N_IRQ-1:0] evt_i,
    input logic [N_IRQ-1:0] raw_q,
    input logic [N_IRQ-1:0] mask_q,
    input logic             irq_o,
    input logic             err_o,
    input logic             rvalid_o,
    input logic [31:0]      rdata_o,
    input logic             pal_sel_o,
    input logic             pal_wr_o,
    input logic [31:0]      pal_rdata_i,
    input logic             disp_en_o
);

    assert_irq_lag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o == $past(|(raw_q & mask_q)));

    assert_set_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && ($past(evt_i) != '0)) |-> ((raw_q & $past(evt_i)) == $past(evt_i)));

    assert_bad_read_zero_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (err_o && rvalid_o) |-> (rdata_o == '0));

    assert_err_follows_access_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> $past(sel_i));

    assert_pal_read_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && $past(pal_sel_o && !pal_wr_o)) |->
            (rvalid_o && !err_o && rdata_o == $past(pal_rdata_i)));

    assert_enable_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && !$past(sel_i && wr_i)) |-> $stable(disp_en_o));

endmodule

bind lcdc_regs lcdc_regs_chk #(.N_IRQ(N_IRQ)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_i       (sel_i),
    .wr_i        (wr_i),
    .evt_i       (evt_i),
    .raw_q       (raw_w),
    .mask_q      (mask_w),
    .irq_o       (irq_o),
    .err_o       (err_o),
    .rvalid_o    (rvalid_o),
    .rdata_o     (rdata_o),
    .pal_sel_o   (pal_sel_o),
    .pal_wr_o    (pal_wr_o),
    .pal_rdata_i (pal_rdata_i),
    .disp_en_o   (disp_en_o)
);

// File: tb/tb_lcdc_regs.sv
`timescale 1ns/1ps
module tb_lcdc_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap = 1'b0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [9:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rvalid;
    logic        err;
    logic [3:0]  evt = '0;
    logic        irq;
    logic        pal_sel;
    logic        pal_wr;
    logic [6:0]  pal_idx;
    logic [31:0] pal_wdata;
    logic [31:0] pal_rdata;
    logic [10:0] lw;
    logic [10:0] lc;
    logic [2:0]  depth;
    logic        bgr, beby, bepx, den;
    logic [31:0] ubase, lbase;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        logic [31:0] data;
        logic        err;
        string       tag;
    } exp_t;
    exp_t sb[$];

    logic [31:0] pal_mem [128];

    always #4 clk = ~clk;

    lcdc_regs dut (
        .clk_i(clk), .rst_ni(rst_n), .strap_swap_i(strap),
        .sel_i(sel), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .rvalid_o(rvalid), .err_o(err),
        .evt_i(evt), .irq_o(irq),
        .pal_sel_o(pal_sel), .pal_wr_o(pal_wr), .pal_idx_o(pal_idx),
        .pal_wdata_o(pal_wdata), .pal_rdata_i(pal_rdata),
        .line_width_o(lw), .line_count_o(lc), .depth_o(depth),
        .bgr_o(bgr), .be_byte_o(beby), .be_pixel_o(bepx), .disp_en_o(den),
        .upper_base_o(ubase), .lower_base_o(lbase)
    );

    // neighbouring palette memory model
    assign pal_rdata = pal_mem[pal_idx];
    always @(posedge clk) if (pal_sel && pal_wr) pal_mem[pal_idx] <= pal_wdata;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read items as read strobes appear
    always @(negedge clk) begin
        if (rst_n && rvalid) begin
            if (sb.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R12 unexpected read strobe actual=1 expected=0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " data"}, rdata, e.data);
                check({e.tag, " err"}, {31'b0, err}, {31'b0, e.err});
            end
        end
    end

    task automatic bus_wr(input logic [11:0] off, input logic [31:0] d,
                          input logic exp_err, input string tag);
        sel = 1'b1; wr = 1'b1; addr = off[11:2]; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
        check({tag, " write err"}, {31'b0, err}, {31'b0, exp_err});
    endtask

    task automatic bus_rd(input logic [11:0] off, input logic [31:0] exp,
                          input logic exp_err, input string tag);
        exp_t e;
        e.data = exp; e.err = exp_err; e.tag = tag;
        sb.push_back(e);
        sel = 1'b1; wr = 1'b0; addr = off[11:2];
        @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] sig [8];
        sig = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        for (int i = 0; i < 128; i++) pal_mem[i] = 32'hA000_0000 + i;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 width", {21'b0, lw}, 32'd16);
        check("R1 count", {21'b0, lc}, 32'd1);
        check("R1 disp_en", {31'b0, den}, 32'd0);
        check("R1 irq", {31'b0, irq}, 32'd0);
        bus_rd(12'h01C, 32'h0, 1'b0, "R1 ctrl");
        bus_rd(12'h020, 32'h0, 1'b0, "R1 raw");

        // R2 plain storage
        bus_wr(12'h008, 32'hDEAD_BEEF, 1'b0, "R2");
        bus_wr(12'h00C, 32'h0123_4567, 1'b0, "R2");
        bus_wr(12'h010, 32'h8000_0000, 1'b0, "R2");
        bus_wr(12'h014, 32'h1234_5678, 1'b0, "R2");
        bus_rd(12'h008, 32'hDEAD_BEEF, 1'b0, "R2 tim2");
        bus_rd(12'h00C, 32'h0123_4567, 1'b0, "R2 tim3");
        check("R2 upper_base", ubase, 32'h8000_0000);
        check("R2 lower_base", lbase, 32'h1234_5678);

        // R9 current address mirrors
        bus_rd(12'h02C, 32'h8000_0000, 1'b0, "R9 ucur");
        bus_rd(12'h030, 32'h1234_5678, 1'b0, "R9 lcur");

        // R3 geometry
        bus_wr(12'h000, 32'hFFFF_FFFF, 1'b0, "R3");
        check("R3 width max", {21'b0, lw}, 32'd1024);
        bus_wr(12'h000, 32'hFFFF_FF07, 1'b0, "R3");
        check("R3 width field1", {21'b0, lw}, 32'd32);
        bus_wr(12'h004, 32'h0000_01DF, 1'b0, "R3");
        check("R3 count 480", {21'b0, lc}, 32'd480);
        bus_wr(12'h004, 32'hFFFF_FC0F, 1'b0, "R3");
        check("R3 count upper ignored", {21'b0, lc}, 32'd16);
        bus_wr(12'h004, 32'h0000_03FF, 1'b0, "R3");
        check("R3 count max", {21'b0, lc}, 32'd1024);
        bus_rd(12'h000, 32'hFFFF_FF07, 1'b0, "R2 tim0");

        // R4 control fields, R5 strap low
        bus_wr(12'h01C, 32'h0000_0E0B, 1'b0, "R4");
        check("R4 depth", {29'b0, depth}, 32'd5);
        check("R4 flags", {29'b0, bgr, beby, bepx}, 32'b011);
        check("R4 disp_en on", {31'b0, den}, 32'd1);
        bus_wr(12'h01C, 32'h0000_0101, 1'b0, "R4");
        check("R4 bgr", {31'b0, bgr}, 32'd1);
        check("R4 disp_en needs power", {31'b0, den}, 32'd0);
        bus_wr(12'h018, 32'h0000_0005, 1'b0, "R5");
        bus_rd(12'h018, 32'h0000_0005, 1'b0, "R5 mask low strap");
        bus_rd(12'h01C, 32'h0000_0101, 1'b0, "R5 ctrl low strap");

        // R5 strap high swaps
        strap = 1'b1;
        bus_wr(12'h018, 32'h0000_0801, 1'b0, "R5");
        check("R5 swapped ctrl write", {31'b0, den}, 32'd1);
        bus_rd(12'h01C, 32'h0000_0005, 1'b0, "R5 mask high strap");
        bus_rd(12'h018, 32'h0000_0801, 1'b0, "R5 ctrl high strap");
        strap = 1'b0;

        // R6 / R8 events and irq latency (mask = 0x5)
        evt = 4'h3;
        @(negedge clk);
        evt = 4'h0;
        check("R8 irq not yet", {31'b0, irq}, 32'd0);
        @(negedge clk);
        check("R8 irq raised", {31'b0, irq}, 32'd1);
        bus_rd(12'h020, 32'h3, 1'b0, "R6 raw");
        bus_rd(12'h024, 32'h1, 1'b0, "R6 masked");

        // R7 clear
        bus_wr(12'h028, 32'h0000_0001, 1'b0, "R7");
        check("R8 irq one cycle late", {31'b0, irq}, 32'd1);
        @(negedge clk);
        check("R8 irq dropped", {31'b0, irq}, 32'd0);
        bus_rd(12'h020, 32'h2, 1'b0, "R7 raw after clear");

        // R7 event and clear in the same cycle
        evt = 4'h4;
        sel = 1'b1; wr = 1'b1; addr = 10'h00A; wdata = 32'h6;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; evt = 4'h0;
        bus_rd(12'h020, 32'h4, 1'b0, "R7 set wins raw");
        bus_rd(12'h024, 32'h4, 1'b0, "R7 set wins masked");
        check("R7 irq kept", {31'b0, irq}, 32'd1);

        // R10 signature
        for (int i = 0; i < 8; i++) begin
            bus_rd(12'hFE0 + 12'(i * 4), {24'b0, sig[i]}, 1'b0, "R10 id");
        end

        // R11 palette pass-through
        bus_wr(12'h204, 32'h0000_ABCD, 1'b0, "R11");
        bus_rd(12'h204, 32'h0000_ABCD, 1'b0, "R11 pal readback");
        bus_rd(12'h3FC, 32'hA000_007F, 1'b0, "R11 pal last");
        bus_rd(12'h200, 32'hA000_0000, 1'b0, "R11 pal first");

        // R12 bad accesses
        bus_rd(12'h034, 32'h0, 1'b1, "R12 unmapped read");
        bus_rd(12'h500, 32'h0, 1'b1, "R12 gap read");
        bus_rd(12'h028, 32'h0, 1'b1, "R12 clear read");
        bus_wr(12'h034, 32'hFFFF_FFFF, 1'b1, "R12");
        bus_wr(12'h020, 32'h0000_0000, 1'b1, "R12");
        bus_wr(12'h02C, 32'h5555_5555, 1'b1, "R12");
        bus_rd(12'h020, 32'h4, 1'b0, "R12 raw untouched");
        bus_rd(12'h010, 32'h8000_0000, 1'b0, "R12 base untouched");
        check("R12 err clears", {31'b0, err}, 32'd0);

        @(negedge clk);
        @(negedge clk);
        if (sb.size() != 0) begin
            n_chk++; n_bad++;
            $display("FAIL R12 missing read strobes actual=%0d expected=0", sb.size());
        end
        finish_run();
    end

endmodule